// File: doc/BRIEF.md
# Self-Clocked Framed Serial Write Port

This block receives 24-bit register writes over a serial line for which it generates the clock itself. The host drives an active-low frame strobe low and holds a register-select line steady. The block then produces a serial clock, divided down from the system clock, on an output with an enable. The clock line counts as released, or pulled high, whenever that enable is low. The host puts each data bit on the data line and the block samples it on the rising clock edge, most significant bit first.

After the 24th bit the block lets the clock fall once more and then releases it. The completed word is copied into either the control register or the calibration register, and a one-cycle completion pulse marks the moment of the copy. If the strobe returns high before the word is complete, the block discards the partial word, stops the clock, and leaves both registers unchanged. A write neither reads nor alters any data-ready indication, so the block has no such signal.

The frame strobe passes through a synchronizer of parameterised depth. The clock half-period, the word width and the reset values of both registers are parameters.

Top module: `selfclk_wr_port`

## Requirements
- R1: After reset `sclk_oe` is 0, `sclk_out` is 1, `wr_done` is 0, and both registers hold their reset values (all zero by default).
- R2: A high-to-low transition of `frame_n` starts a write. `sclk_oe` goes to 1 exactly SYNC_STAGES+1 clock edges after the first edge that samples `frame_n` low. `sclk_out` is 0 in that first enabled cycle.
- R3: While enabled, `sclk_out` has a period of 2*SCLK_HALF system clocks, with each level lasting SCLK_HALF clocks.
- R4: A data bit is sampled on each rising `sclk_out` edge. The first sampled bit becomes bit 23, the most significant bit, of the stored word.
- R5: A complete write produces exactly 24 rising `sclk_out` edges. After the 24th high phase `sclk_out` falls, stays low for one system clock with `sclk_oe` still 1, and then `sclk_oe` returns to 0.
- R6: With `reg_sel` at 0 the word goes to `ctrl_word`; with `reg_sel` at 1 it goes to `cal_word`. The other register keeps its value.
- R7: The destination register changes only once all 24 bits have arrived, in the same cycle as a single-cycle `wr_done` pulse. Neither register changes in any other cycle.
- R8: If `frame_n` rises before the 24th bit is sampled, no register changes and no `wr_done` pulse occurs. `sclk_oe` drops SYNC_STAGES+1 edges after the rise is first sampled, and no further rising clock edges follow.
- R9: `reg_sel` is captured when the write starts. Changing it during the write does not change the destination.
- R10: Holding `frame_n` low after a completed write does not start another write. Only a fresh high-to-low transition does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Active-low write frame strobe from the host |
| reg_sel | input | 1 | Destination select: 0 control, 1 calibration |
| sdata | input | 1 | Serial data from the host, sampled on rising `sclk_out` |
| sclk_out | output | 1 | Generated serial clock (reads 1 when released) |
| sclk_oe | output | 1 | Output enable for the serial clock driver |
| ctrl_word | output | WORD_BITS | Control register contents |
| cal_word | output | WORD_BITS | Calibration register contents |
| wr_done | output | 1 | One-cycle pulse when a complete word is stored |

## Verification
`sclk_oe` is due SYNC_STAGES+1 edges after the strobe's fall is sampled. After that each level of the serial clock lasts SCLK_HALF clocks, so the bench changes data one system clock after a falling edge and checks the spacing of rising edges at falling system-clock edges. The stored word and `wr_done` appear one system clock after the edge that raises the serial clock for the 24th bit. The scoreboard monitor compares the registers in that `wr_done` cycle. `sclk_oe` returns low SCLK_HALF+1 clocks after the same edge. After an early strobe rise the bench waits SYNC_STAGES+2 falling clock edges before it checks that the clock stopped, and it then confirms that the register contents did not change.

// File: rtl/swp_pkg.sv
package swp_pkg;
   // write sequencer states
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SHIFT = 2'd1,
      ST_TAIL  = 2'd2
   } wr_state_e;

   // destination indices, decoded from the captured select level
   localparam int DEST_CTRL = 0;
   localparam int DEST_CAL  = 1;
   localparam int NUM_DEST  = 2;
endpackage

// File: rtl/swp_frame_sync.sv
module swp_frame_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din_n,
   output logic dout_n
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign dout_n = din_n;
      end else if (STAGES == 1) begin : g_single
         logic stage_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q <= 1'b1;
            else        stage_q <= din_n;
         end
         assign dout_n = stage_q;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= {chain_q[STAGES-2:0], din_n};
         end
         assign dout_n = chain_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/swp_sclk_gen.sv
module swp_sclk_gen #(
   parameter int HALF = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic level,
   output logic rise,
   output logic fall
);
   localparam int CNT_W = (HALF > 1) ? $clog2(HALF) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF - 1);

   logic [CNT_W-1:0] cnt_q;
   logic             lvl_q;
   logic             tick;

   assign tick = run && (cnt_q == LAST);
   assign rise = tick && !lvl_q;
   assign fall = tick &&  lvl_q;
   assign level = lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         lvl_q <= 1'b0;
      end else if (!run) begin
         cnt_q <= '0;
         lvl_q <= 1'b0;
      end else if (tick) begin
         cnt_q <= '0;
         lvl_q <= !lvl_q;
      end else begin
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end
endmodule

// File: rtl/swp_shift_in.sv
module swp_shift_in #(
   parameter int WORD_BITS = 24
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clear,
   input  logic                 cap_en,
   input  logic                 sdata,
   output logic [WORD_BITS-1:0] word,
   output logic                 word_vld,
   output logic                 all_in
);
   localparam int CNT_W = $clog2(WORD_BITS + 1);
   localparam logic [CNT_W-1:0] FINAL_IDX = CNT_W'(WORD_BITS - 1);
   localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(WORD_BITS);

   logic [WORD_BITS-1:0] shreg_q;
   logic [WORD_BITS-1:0] shreg_nxt;
   logic [CNT_W-1:0]     cnt_q;
   logic                 vld_q;

   assign shreg_nxt = {shreg_q[WORD_BITS-2:0], sdata};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg_q <= '0;
         cnt_q   <= '0;
         vld_q   <= 1'b0;
      end else begin
         vld_q <= 1'b0;
         if (clear) begin
            shreg_q <= '0;
            cnt_q   <= '0;
         end else if (cap_en && (cnt_q != FULL_CNT)) begin
            shreg_q <= shreg_nxt;
            cnt_q   <= cnt_q + CNT_W'(1);
            if (cnt_q == FINAL_IDX) vld_q <= 1'b1;
         end
      end
   end

   assign word     = shreg_q;
   assign word_vld = vld_q;
   assign all_in   = (cnt_q == FULL_CNT);
endmodule

// File: rtl/swp_reg_bank.sv
module swp_reg_bank
   import swp_pkg::*;
#(
   parameter int                   WORD_BITS = 24,
   parameter logic [WORD_BITS-1:0] CTRL_RST  = '0,
   parameter logic [WORD_BITS-1:0] CAL_RST   = '0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load,
   input  logic                 dest,
   input  logic [WORD_BITS-1:0] word,
   output logic [WORD_BITS-1:0] ctrl_word,
   output logic [WORD_BITS-1:0] cal_word,
   output logic                 done
);
   logic [WORD_BITS-1:0] regs_q [NUM_DEST];
   logic                 done_q;

   generate
      for (genvar d = 0; d < NUM_DEST; d++) begin : g_dest
         localparam logic [WORD_BITS-1:0] RST_VAL =
            (d == DEST_CTRL) ? CTRL_RST : CAL_RST;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          regs_q[d] <= RST_VAL;
            else if (load && (int'(dest) == d))  regs_q[d] <= word;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) done_q <= 1'b0;
      else        done_q <= load;
   end

   assign ctrl_word = regs_q[DEST_CTRL];
   assign cal_word  = regs_q[DEST_CAL];
   assign done      = done_q;
endmodule

// File: rtl/selfclk_wr_port.sv
module selfclk_wr_port
   import swp_pkg::*;
#(
   parameter int                   WORD_BITS   = 24,
   parameter int                   SCLK_HALF   = 2,
   parameter int                   SYNC_STAGES = 2,
   parameter logic [WORD_BITS-1:0] CTRL_RST    = '0,
   parameter logic [WORD_BITS-1:0] CAL_RST     = '0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 frame_n,
   input  logic                 reg_sel,
   input  logic                 sdata,
   output logic                 sclk_out,
   output logic                 sclk_oe,
   output logic [WORD_BITS-1:0] ctrl_word,
   output logic [WORD_BITS-1:0] cal_word,
   output logic                 wr_done
);
   // elaboration-time parameter checks
   generate
      if (WORD_BITS < 2) begin : g_bad_width
         $error("selfclk_wr_port: WORD_BITS must be at least 2");
      end
      if (SCLK_HALF < 1) begin : g_bad_half
         $error("selfclk_wr_port: SCLK_HALF must be at least 1");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("selfclk_wr_port: SYNC_STAGES must lie in 0..4");
      end
   endgenerate

   wr_state_e            state_q;
   logic                 frame_s_n;
   logic                 frame_prev_q;
   logic                 sel_q;
   logic                 start;
   logic                 abort;
   logic                 run;
   logic                 lvl;
   logic                 rise;
   logic                 fall;
   logic                 cap_en;
   logic [WORD_BITS-1:0] word;
   logic                 word_vld;
   logic                 all_in;

   swp_frame_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .din_n  (frame_n),
      .dout_n (frame_s_n)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) frame_prev_q <= 1'b1;
      else        frame_prev_q <= frame_s_n;
   end

   assign start  = (state_q == ST_IDLE) && frame_prev_q && !frame_s_n;
   assign abort  = (state_q == ST_SHIFT) && frame_s_n;
   assign run    = (state_q == ST_SHIFT);
   assign cap_en = rise && !frame_s_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         sel_q   <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (start) begin
                  state_q <= ST_SHIFT;
                  sel_q   <= reg_sel;
               end
            end
            ST_SHIFT: begin
               if (abort)               state_q <= ST_IDLE;
               else if (fall && all_in) state_q <= ST_TAIL;
            end
            ST_TAIL:  state_q <= ST_IDLE;
            default:  state_q <= ST_IDLE;
         endcase
      end
   end

   swp_sclk_gen #(.HALF(SCLK_HALF)) u_clkgen (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .level (lvl),
      .rise  (rise),
      .fall  (fall)
   );

   swp_shift_in #(.WORD_BITS(WORD_BITS)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (start),
      .cap_en   (cap_en),
      .sdata    (sdata),
      .word     (word),
      .word_vld (word_vld),
      .all_in   (all_in)
   );

   swp_reg_bank #(
      .WORD_BITS (WORD_BITS),
      .CTRL_RST  (CTRL_RST),
      .CAL_RST   (CAL_RST)
   ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (word_vld),
      .dest      (sel_q),
      .word      (word),
      .ctrl_word (ctrl_word),
      .cal_word  (cal_word),
      .done      (wr_done)
   );

   assign sclk_oe  = (state_q != ST_IDLE);
   assign sclk_out = sclk_oe ? lvl : 1'b1;
endmodule

// File: rtl/swp_checker.sv
module swp_checker #(
   parameter int WORD_BITS = 24,
   parameter int SCLK_HALF = 2
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 sclk_out,
   input logic                 sclk_oe,
   input logic [WORD_BITS-1:0] ctrl_word,
   input logic [WORD_BITS-1:0] cal_word,
   input logic                 wr_done
);
   logic prev_out_q;
   logic prev_oe_q;
   int   run_len_q;
   int   rise_cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_out_q <= 1'b1;
         prev_oe_q  <= 1'b0;
         run_len_q  <= 0;
         rise_cnt_q <= 0;
      end else begin
         prev_out_q <= sclk_out;
         prev_oe_q  <= sclk_oe;
         if (!sclk_oe)                                      run_len_q <= 0;
         else if (!prev_oe_q || (sclk_out != prev_out_q))   run_len_q <= 1;
         else                                               run_len_q <= run_len_q + 1;
         if (!sclk_oe)                                      rise_cnt_q <= 0;
         else if (prev_oe_q && sclk_out && !prev_out_q)     rise_cnt_q <= rise_cnt_q + 1;
      end
   end

   // R2
   start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sclk_oe) |-> !sclk_out);

   // R3
   half_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk_oe && prev_oe_q && (sclk_out != prev_out_q)) |-> (run_len_q == SCLK_HALF));

   // R5
   tail_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk_oe && prev_oe_q && (rise_cnt_q == WORD_BITS) && prev_out_q && !sclk_out)
      |=> !sclk_oe);

   // R5
   bit_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_done |-> (rise_cnt_q == WORD_BITS));

   // R7
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_done |=> !wr_done);

   // R7
   ctrl_atomic_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ctrl_word) |-> wr_done);

   // R7
   cal_atomic_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cal_word) |-> wr_done);

   // R6
   one_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_done |-> ($stable(ctrl_word) || $stable(cal_word)));
endmodule

bind selfclk_wr_port swp_checker #(
   .WORD_BITS (WORD_BITS),
   .SCLK_HALF (SCLK_HALF)
) u_swp_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sclk_out  (sclk_out),
   .sclk_oe   (sclk_oe),
   .ctrl_word (ctrl_word),
   .cal_word  (cal_word),
   .wr_done   (wr_done)
);

// File: tb/selfclk_wr_port_bench.sv
module selfclk_wr_port_bench;
   localparam int CLK_PERIOD = 10;
   localparam int W    = 24;
   localparam int HALF = 2;   // abort timing below relies on HALF=2, SYNC=2
   localparam int SYNC = 2;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         frame_n = 1'b1;
   logic         reg_sel = 1'b0;
   logic         sdata = 1'b0;
   logic         sclk_out;
   logic         sclk_oe;
   logic [W-1:0] ctrl_word;
   logic [W-1:0] cal_word;
   logic         wr_done;

   selfclk_wr_port #(
      .WORD_BITS   (W),
      .SCLK_HALF   (HALF),
      .SYNC_STAGES (SYNC)
   ) u_selfclk_wr_port (
      .clk       (clk),
      .rst_n     (rst_n),
      .frame_n   (frame_n),
      .reg_sel   (reg_sel),
      .sdata     (sdata),
      .sclk_out  (sclk_out),
      .sclk_oe   (sclk_oe),
      .ctrl_word (ctrl_word),
      .cal_word  (cal_word),
      .wr_done   (wr_done)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   typedef struct packed {
      logic         sel;
      logic [W-1:0] word;
   } exp_t;

   exp_t         exp_q[$];
   int           checks = 0;
   int           errors = 0;
   logic [W-1:0] m_ctrl = '0;
   logic [W-1:0] m_cal  = '0;
   bit           stray = 1'b0;
   bit           prev_done = 1'b0;
   logic         prev_out = 1'b1;
   logic         prev_oe = 1'b0;
   int           cyc = 0;
   int           last_rise = -1;
   int           rises = 0;
   int           oe_cycles = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // monitor: scoreboard pop, edge spacing, stray register changes
   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         if (sclk_oe) oe_cycles++;
         if (sclk_oe && prev_oe && sclk_out && !prev_out) begin
            rises++;
            if (last_rise >= 0)
               chk((cyc - last_rise) == 2*HALF, "R3", "rise spacing",
                   32'(cyc - last_rise), 32'(2*HALF));
            last_rise = cyc;
         end
         if (!sclk_oe) last_rise = -1;
         if (wr_done) begin
            if (prev_done) chk(1'b0, "R7", "done wider than one cycle", 1, 0);
            if (exp_q.size() == 0) begin
               chk(1'b0, "R8", "unexpected wr_done", 1, 0);
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               if (e.sel) m_cal = e.word; else m_ctrl = e.word;
               chk(ctrl_word == m_ctrl, "R4/R6", "ctrl_word", 32'(ctrl_word), 32'(m_ctrl));
               chk(cal_word == m_cal, "R4/R6", "cal_word", 32'(cal_word), 32'(m_cal));
            end
         end else if (ctrl_word != m_ctrl || cal_word != m_cal) begin
            stray = 1'b1;
         end
         prev_done = wr_done;
         prev_out  = sclk_out;
         prev_oe   = sclk_oe;
      end
   end

   // driver: one frame; nbits < W aborts after that many rising edges
   task automatic write_word(input logic sel, input logic [W-1:0] w,
                             input int nbits, input bit flip_sel, input int hold);
      exp_t e;
      if (nbits == W) begin
         e.sel  = sel;
         e.word = w;
         exp_q.push_back(e);
      end
      @(negedge clk);
      reg_sel = sel;
      sdata   = w[W-1];
      rises   = 0;
      frame_n = 1'b0;
      repeat (SYNC) @(negedge clk);
      chk(!sclk_oe, "R2", "oe before start latency", 32'(sclk_oe), 0);
      @(negedge clk);
      chk(sclk_oe && !sclk_out, "R2", "oe/clk at start", {sclk_oe, sclk_out}, 32'b10);
      for (int i = 0; i < nbits; i++) begin
         @(posedge sclk_out);
         @(negedge clk);
         if (flip_sel && i == W/2) reg_sel = ~sel;   // R9 stimulus
         if (i == nbits - 1) begin
            if (nbits < W) frame_n = 1'b1;
         end else begin
            @(negedge sclk_out);
            @(negedge clk);
            sdata = w[W-2-i];
         end
      end
      if (nbits == W) begin
         @(negedge sclk_out);
         @(negedge clk);
         chk(sclk_oe && !sclk_out, "R5", "tail low phase", {sclk_oe, sclk_out}, 32'b10);
         @(negedge clk);
         chk(!sclk_oe && sclk_out, "R5", "clock released", {sclk_oe, sclk_out}, 32'b01);
         chk(rises == W, "R5", "rising edge count", 32'(rises), 32'(W));
         oe_cycles = 0;
         repeat (hold) @(negedge clk);
         chk(oe_cycles == 0, "R10", "restart while strobe held low", 32'(oe_cycles), 0);
         frame_n = 1'b1;
         repeat (4) @(negedge clk);
      end else begin
         repeat (SYNC + 2) @(negedge clk);
         chk(!sclk_oe, "R8", "oe after abort", 32'(sclk_oe), 0);
         repeat (8) @(negedge clk);
         chk(rises == nbits, "R8", "rises after abort", 32'(rises), 32'(nbits));
         chk(ctrl_word == m_ctrl && cal_word == m_cal, "R8", "regs after abort",
             32'(ctrl_word ^ cal_word), 32'(m_ctrl ^ m_cal));
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!sclk_oe && sclk_out && !wr_done, "R1", "idle outputs",
          {sclk_oe, sclk_out, wr_done}, 32'b010);
      chk(ctrl_word == '0 && cal_word == '0, "R1", "reset registers",
          32'(ctrl_word | cal_word), 0);

      write_word(1'b0, 24'hA5C3F0, W, 1'b0, 0);   // R6 control
      write_word(1'b1, 24'hFFFFFF, W, 1'b0, 0);   // R6 calibration
      write_word(1'b0, 24'h000001, W, 1'b0, 20);  // R4 LSB only, R10 hold
      write_word(1'b1, 24'h800000, W, 1'b0, 0);   // R4 MSB only
      write_word(1'b0, 24'h123456, 10, 1'b0, 0);  // R8 early abort
      write_word(1'b1, 24'h654321, W-1, 1'b0, 0); // R8 abort one bit short
      write_word(1'b1, 24'h3C5A69, W, 1'b1, 0);   // R9 select flipped mid-write
      write_word(1'b0, 24'h5AA55A, W, 1'b0, 6);   // back-to-back after hold

      repeat (10) @(negedge clk);
      chk(exp_q.size() == 0, "R7", "pending expected words", 32'(exp_q.size()), 0);
      chk(!stray, "R7", "register changed outside wr_done", 32'(stray), 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule